// File: doc/BRIEF.md
# Input colour conversion matrix

This block is a per-pixel 3x4 affine colour conversion stage. Each cycle it can accept one pixel of three unsigned channels, for example luma and two chroma samples or an RGB triplet. It produces red, green and blue, each a weighted sum of the three inputs plus a constant. Two coefficient banks are held side by side and written word by word through a simple configuration write port. A small mode state machine selects whether pixels pass through untouched, use bank A or use bank B. Software can therefore build a new matrix in the idle bank and switch to it between two pixels.

Each result is accumulated at full precision and rounded to nearest at the 13-bit fractional point. It is then clamped to the unsigned output range and leaves the block a fixed three cycles after the pixel entered, with its own valid flag. The coefficients and the bank choice are captured together with the pixel in the first pipeline stage. Writes therefore never disturb a pixel that is already in flight.

The mode state machine has three states: PASS (reset state), BANK_A and BANK_B. A configuration write to the mode address moves it from any state to the state named by the written value: 0 goes to PASS, 1 to BANK_A and 2 to BANK_B. A write of value 3, a write to any other address, or no write keeps the current state.

Top module: `csc_matrix_top`

## Requirements
- R1: After reset, pix_valid_out is low, all three outputs are zero, the mode is PASS and every coefficient of both banks is zero, so switching to a bank without loading it yields all-zero pixels.
- R2: Every pixel accepted with pix_valid_in high produces exactly one result with pix_valid_out high three clock cycles later. Results come out in input order and back-to-back pixels are supported.
- R3: In PASS mode, pix_out_r, pix_out_g and pix_out_b equal pix_in0, pix_in1 and pix_in2 of the same pixel, with the same three-cycle latency.
- R4: A write with cfg_addr = 6 sets the mode from cfg_wdata[1:0]: 0 selects PASS, 1 selects bank A, 2 selects bank B. The value 3 is ignored and the mode is unchanged.
- R5: A write with cfg_addr = k (0..5) loads, into the bank given by cfg_bank (0 = A, 1 = B), coefficient 2k from cfg_wdata[15:0] and coefficient 2k+1 from cfg_wdata[31:16]. Coefficients 4r..4r+3 form the row of output r (0 red, 1 green, 2 blue); their first three weight pix_in0, pix_in1 and pix_in2, and the fourth is the offset.
- R6: Coefficients are 16-bit two's complement with 13 fractional bits (0x2000 = 1.0). An output is floor((c0*x0 + c1*x1 + c2*x2 + c3*2^DATA_W + 2^12) / 2^13), so halves round upward.
- R7: A result below zero is output as 0, and a result above 2^DATA_W-1 is output as 2^DATA_W-1.
- R8: A mode or coefficient write takes effect for pixels accepted in later cycles. A pixel accepted in the same cycle as a write, or already in the pipeline, uses the settings from before the write.
- R9: Writing the bank that is not selected has no effect on the outputs.
- R10: While pix_valid_out is low, the three outputs hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Target bank of a coefficient write (0 = A, 1 = B) |
| cfg_addr | input | 3 | Word address: 0..5 coefficient pairs, 6 mode |
| cfg_wdata | input | 32 | Write data |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in0 | input | DATA_W | Input channel 0 |
| pix_in1 | input | DATA_W | Input channel 1 |
| pix_in2 | input | DATA_W | Input channel 2 |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out_r | output | DATA_W | Red result |
| pix_out_g | output | DATA_W | Green result |
| pix_out_b | output | DATA_W | Blue result |

## Verification
The assertions check four things on every cycle: the three-cycle valid alignment, the exact pass-through of pixels that entered in PASS mode, the mode state after each legal or illegal mode write, and output hold while no result is valid. The bench's reference-model scenarios are the only evidence for the arithmetic itself: rounding of halves, clamping at both ends, the word and field layout of the coefficients, and the isolation of the idle bank. The same applies to the same-cycle ordering of writes against pixels.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int COEF_W        = 16;
    localparam int FRAC_W        = 13;
    localparam int ROWS          = 3;
    localparam int COEFS_PER_ROW = 4;
    localparam int NUM_COEF      = ROWS * COEFS_PER_ROW;
    localparam int WORDS         = NUM_COEF / 2;
    localparam int ADDR_W        = 3;
    localparam int WDATA_W       = 2 * COEF_W;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd6;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_BANK_A = 2'd1,
        MODE_BANK_B = 2'd2
    } csc_mode_e;
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
#(
    parameter logic BANK_ID = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic                         bank_sel,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [WDATA_W-1:0]           wdata,
    output logic [NUM_COEF*COEF_W-1:0]   coef_o
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WDATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (bank_sel == BANK_ID) && (addr == ADDR_W'(w))) begin
                word_q <= wdata;
            end
        end
        // low half is the even coefficient, high half the odd one
        assign coef_o[w*WDATA_W +: WDATA_W] = word_q;
    end
endmodule

// File: rtl/csc_mode_fsm.sv
module csc_mode_fsm
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        value,
    output csc_mode_e         state_o,
    output logic              pass_o,
    output logic              use_b_o
);
    csc_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_PASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (we && addr == ADDR_MODE) begin
            unique case (value)
                2'd0:    state_d = MODE_PASS;
                2'd1:    state_d = MODE_BANK_A;
                2'd2:    state_d = MODE_BANK_B;
                default: state_d = state_q;
            endcase
        end
    end

    always_comb begin
        pass_o  = 1'b0;
        use_b_o = 1'b0;
        unique case (state_q)
            MODE_PASS:   pass_o  = 1'b1;
            MODE_BANK_A: use_b_o = 1'b0;
            MODE_BANK_B: use_b_o = 1'b1;
            default:     pass_o  = 1'b1;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/csc_channel_dp.sv
module csc_channel_dp
    import csc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            vld_s1,
    input  logic                            vld_s2,
    input  logic                            pass_i,
    input  logic [DATA_W-1:0]               x0,
    input  logic [DATA_W-1:0]               x1,
    input  logic [DATA_W-1:0]               x2,
    input  logic [DATA_W-1:0]               byp_i,
    input  logic [COEFS_PER_ROW*COEF_W-1:0] row_i,
    output logic [DATA_W-1:0]               y_o
);
    localparam int PROD_W = COEF_W + DATA_W + 1;
    localparam int ACC_W  = COEF_W + DATA_W + 3;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic [DATA_W-1:0] MAXV = {DATA_W{1'b1}};

    logic signed [COEF_W-1:0] c0, c1, c2, c3;
    assign c0 = row_i[0*COEF_W +: COEF_W];
    assign c1 = row_i[1*COEF_W +: COEF_W];
    assign c2 = row_i[2*COEF_W +: COEF_W];
    assign c3 = row_i[3*COEF_W +: COEF_W];

    // stage 2: products at full precision
    logic signed [PROD_W-1:0] p0_q, p1_q, p2_q;
    logic signed [ACC_W-1:0]  off_q;
    logic                     pass_q;
    logic [DATA_W-1:0]        byp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_q   <= '0;
            p1_q   <= '0;
            p2_q   <= '0;
            off_q  <= '0;
            pass_q <= 1'b0;
            byp_q  <= '0;
        end else if (vld_s1) begin
            p0_q   <= c0 * $signed({1'b0, x0});
            p1_q   <= c1 * $signed({1'b0, x1});
            p2_q   <= c2 * $signed({1'b0, x2});
            off_q  <= {{(ACC_W-COEF_W-DATA_W){c3[COEF_W-1]}}, c3, {DATA_W{1'b0}}};
            pass_q <= pass_i;
            byp_q  <= byp_i;
        end
    end

    // stage 3: sum, round, clamp
    logic signed [ACC_W-1:0] acc, sh;
    logic [DATA_W-1:0]       sat;
    always_comb begin
        acc = {{2{p0_q[PROD_W-1]}}, p0_q} + {{2{p1_q[PROD_W-1]}}, p1_q}
            + {{2{p2_q[PROD_W-1]}}, p2_q} + off_q + RND;
        sh  = acc >>> FRAC_W;
        if (sh[ACC_W-1])                  sat = '0;
        else if (|sh[ACC_W-2:DATA_W])     sat = MAXV;
        else                              sat = sh[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      y_o <= '0;
        else if (vld_s2) y_o <= pass_q ? byp_q : sat;
    end
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
    import csc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_bank,
    input  logic [2:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               pix_valid_in,
    input  logic [DATA_W-1:0]  pix_in0,
    input  logic [DATA_W-1:0]  pix_in1,
    input  logic [DATA_W-1:0]  pix_in2,
    output logic               pix_valid_out,
    output logic [DATA_W-1:0]  pix_out_r,
    output logic [DATA_W-1:0]  pix_out_g,
    output logic [DATA_W-1:0]  pix_out_b
);
    localparam int ROW_BITS  = COEFS_PER_ROW * COEF_W;
    localparam int BANK_BITS = NUM_COEF * COEF_W;

    logic [BANK_BITS-1:0] bank_coef [2];
    for (genvar b = 0; b < 2; b++) begin : g_bank
        csc_coef_bank #(.BANK_ID(1'(b))) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (cfg_we),
            .bank_sel (cfg_bank),
            .addr     (cfg_addr),
            .wdata    (cfg_wdata),
            .coef_o   (bank_coef[b])
        );
    end

    csc_mode_e mode_state;
    logic      mode_pass, mode_use_b;
    csc_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .value   (cfg_wdata[1:0]),
        .state_o (mode_state),
        .pass_o  (mode_pass),
        .use_b_o (mode_use_b)
    );

    // stage 1: pixel and its coefficient set captured together
    logic                 s1_vld, s2_vld;
    logic                 s1_pass;
    logic [DATA_W-1:0]    s1_px [ROWS];
    logic [BANK_BITS-1:0] s1_coef;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_pass <= 1'b1;
            s1_coef <= '0;
            for (int i = 0; i < ROWS; i++) s1_px[i] <= '0;
        end else begin
            s1_vld <= pix_valid_in;
            if (pix_valid_in) begin
                s1_pass  <= mode_pass;
                s1_coef  <= mode_use_b ? bank_coef[1] : bank_coef[0];
                s1_px[0] <= pix_in0;
                s1_px[1] <= pix_in1;
                s1_px[2] <= pix_in2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld        <= 1'b0;
            pix_valid_out <= 1'b0;
        end else begin
            s2_vld        <= s1_vld;
            pix_valid_out <= s2_vld;
        end
    end

    logic [DATA_W-1:0] ch_out [ROWS];
    for (genvar r = 0; r < ROWS; r++) begin : g_chan
        csc_channel_dp #(.DATA_W(DATA_W)) u_dp (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_s1 (s1_vld),
            .vld_s2 (s2_vld),
            .pass_i (s1_pass),
            .x0     (s1_px[0]),
            .x1     (s1_px[1]),
            .x2     (s1_px[2]),
            .byp_i  (s1_px[r]),
            .row_i  (s1_coef[r*ROW_BITS +: ROW_BITS]),
            .y_o    (ch_out[r])
        );
    end

    assign pix_out_r = ch_out[0];
    assign pix_out_g = ch_out[1];
    assign pix_out_b = ch_out[2];
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              pix_valid_in,
    input logic [DATA_W-1:0] pix_in0,
    input logic [DATA_W-1:0] pix_in1,
    input logic [DATA_W-1:0] pix_in2,
    input logic              pix_valid_out,
    input logic [DATA_W-1:0] pix_out_r,
    input logic [DATA_W-1:0] pix_out_g,
    input logic [DATA_W-1:0] pix_out_b,
    input logic [1:0]        mode_state
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pix_valid_out == $past(pix_valid_in, 3)));

    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pix_valid_out && $past(mode_state, 3) == 2'd0)
        |-> (pix_out_r == $past(pix_in0, 3) && pix_out_g == $past(pix_in1, 3)
             && pix_out_b == $past(pix_in2, 3)));

    a_r4_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd6 && cfg_wdata[1:0] != 2'd3)
        |=> (mode_state == $past(cfg_wdata[1:0])));

    a_r4_mode_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd6 && cfg_wdata[1:0] == 2'd3)
        |=> $stable(mode_state));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !pix_valid_out)
        |-> ($stable(pix_out_r) && $stable(pix_out_g) && $stable(pix_out_b)));
endmodule

bind csc_matrix_top csc_matrix_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .pix_valid_in  (pix_valid_in),
    .pix_in0       (pix_in0),
    .pix_in1       (pix_in1),
    .pix_in2       (pix_in2),
    .pix_valid_out (pix_valid_out),
    .pix_out_r     (pix_out_r),
    .pix_out_g     (pix_out_g),
    .pix_out_b     (pix_out_b),
    .mode_state    (mode_state)
);

// File: tb/csc_matrix_top_tb_top.sv
module csc_matrix_top_tb_top;
    localparam int W    = 12;
    localparam int MAXV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_bank = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          pix_valid_in = 1'b0;
    logic [W-1:0]  pix_in0 = '0, pix_in1 = '0, pix_in2 = '0;
    logic          pix_valid_out;
    logic [W-1:0]  pix_out_r, pix_out_g, pix_out_b;

    always #4 clk = ~clk;

    csc_matrix_top #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pix_valid_in(pix_valid_in),
        .pix_in0(pix_in0), .pix_in1(pix_in1), .pix_in2(pix_in2),
        .pix_valid_out(pix_valid_out), .pix_out_r(pix_out_r),
        .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // reference state
    int mdl_coef [2][12];
    int mdl_mode = 0;

    logic [3*W-1:0] exp_q [$];
    string          tag_q [$];
    logic [3*W-1:0] last_out = '0;
    int             seen = 0, sent = 0;

    function automatic int ref_chan(int bank, int row, int x0, int x1, int x2);
        longint acc;
        acc = longint'(mdl_coef[bank][row*4+0]) * x0 + longint'(mdl_coef[bank][row*4+1]) * x1
            + longint'(mdl_coef[bank][row*4+2]) * x2 + longint'(mdl_coef[bank][row*4+3]) * (1 << W)
            + 4096;
        acc = acc >>> 13;
        if (acc < 0) return 0;
        if (acc > MAXV) return MAXV;
        return int'(acc);
    endfunction

    task automatic check(string req, bit ok, string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic step(bit we, bit bank, int addr, logic [31:0] data,
                        bit pv, int x0, int x1, int x2, string tag);
        if (pv) begin
            logic [3*W-1:0] e;
            if (mdl_mode == 0) e = {W'(x0), W'(x1), W'(x2)};
            else e = {W'(ref_chan(mdl_mode-1, 0, x0, x1, x2)),
                      W'(ref_chan(mdl_mode-1, 1, x0, x1, x2)),
                      W'(ref_chan(mdl_mode-1, 2, x0, x1, x2))};
            exp_q.push_back(e);
            tag_q.push_back(tag);
            sent++;
        end
        if (we) begin
            if (addr < 6) begin
                mdl_coef[bank][2*addr]   = int'($signed(data[15:0]));
                mdl_coef[bank][2*addr+1] = int'($signed(data[31:16]));
            end else if (addr == 6 && data[1:0] != 2'd3) begin
                mdl_mode = int'(data[1:0]);
            end
        end
        cfg_we = we; cfg_bank = bank; cfg_addr = 3'(addr); cfg_wdata = data;
        pix_valid_in = pv; pix_in0 = W'(x0); pix_in1 = W'(x1); pix_in2 = W'(x2);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic wr(bit bank, int addr, logic [31:0] data);
        step(1, bank, addr, data, 0, 0, 0, 0, "");
    endtask

    task automatic px(int x0, int x1, int x2, string tag);
        step(0, 0, 0, 0, 1, x0, x1, x2, tag);
    endtask

    task automatic load(bit bank, input int m [12]);
        for (int k = 0; k < 6; k++)
            wr(bank, k, {m[2*k+1][15:0], m[2*k][15:0]});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pix_valid_out && !finished) begin
            logic [3*W-1:0] got;
            got = {pix_out_r, pix_out_g, pix_out_b};
            seen++;
            if (exp_q.size() == 0) begin
                check("R2", 0, "result with no pixel pending");
            end else begin
                logic [3*W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, got == e, $sformatf("got r=%0d g=%0d b=%0d exp r=%0d g=%0d b=%0d",
                      got[3*W-1:2*W], got[2*W-1:W], got[W-1:0],
                      e[3*W-1:2*W], e[2*W-1:W], e[W-1:0]));
            end
            last_out = got;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ident [12] = '{8192,0,0,0, 0,8192,0,0, 0,0,8192,0};
        int perm  [12] = '{0,0,8192,0, 8192,0,0,0, 0,8192,0,0};
        int yuv   [12] = '{8192,0,12901,-6450, 8192,-1534,-3835,2685, 8192,15201,0,-7600};
        int sat   [12] = '{16384,0,0,0, 8192,0,0,-8192, 4096,0,0,0};
        int junk  [12] = '{-1,-1,-1,-1, 777,777,777,777, 5,5,5,5};
        for (int b = 0; b < 2; b++) for (int i = 0; i < 12; i++) mdl_coef[b][i] = 0;

        repeat (3) @(negedge clk);
        check("R1", pix_valid_out == 0 && pix_out_r == 0 && pix_out_g == 0 && pix_out_b == 0,
              $sformatf("got v=%0b r=%0d g=%0d b=%0d exp all 0", pix_valid_out,
                        pix_out_r, pix_out_g, pix_out_b));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", pix_valid_out == 0, $sformatf("got v=%0b exp 0", pix_valid_out));

        // R3: bypass after reset, back-to-back
        px(100, 2000, 4095, "R3");
        px(0, 1, 2, "R3");
        px(4095, 4095, 0, "R3");
        idle(4);

        // R1: unloaded bank A gives zero
        wr(0, 6, 1);
        px(1234, 567, 89, "R1");
        idle(4);

        // R2: latency measured at the port
        wr(0, 6, 0);
        px(7, 8, 9, "R2");
        idle(1);
        check("R2", pix_valid_out == 0, $sformatf("cycle 2 got v=%0b exp 0", pix_valid_out));
        idle(1);
        check("R2", pix_valid_out == 1, $sformatf("cycle 3 got v=%0b exp 1", pix_valid_out));
        idle(3);

        // R6: identity in bank A
        load(0, ident);
        wr(0, 6, 1);
        px(10, 20, 30, "R6");
        px(4095, 0, 2048, "R6");
        idle(4);

        // R5: permutation loaded into A shows field layout
        load(0, perm);
        px(11, 22, 33, "R5");
        px(4000, 5, 600, "R5");
        idle(4);

        // R6: colour-difference matrix in B, switch to B
        load(1, yuv);
        wr(0, 6, 2);
        px(2048, 2048, 2048, "R6");
        px(1000, 3000, 500, "R6");
        px(3500, 200, 3900, "R6");
        px(0, 0, 0, "R6");
        idle(4);

        // R7 + R6 rounding: gain 2, negative offset, half gain
        load(1, sat);
        px(4000, 0, 0, "R7");
        px(100, 0, 0, "R7");
        px(3, 0, 0, "R6");
        px(1, 0, 0, "R6");
        px(2100, 0, 0, "R7");
        idle(4);

        // R9: rewrite idle bank A while B is active
        load(0, junk);
        px(1500, 10, 20, "R9");
        idle(4);

        // R4: value 3 ignored
        wr(0, 6, 3);
        px(4000, 1, 2, "R4");
        idle(4);

        // R8: mode write and pixel in the same cycle, then follow-up
        load(0, ident);
        step(1, 0, 6, 1, 1, 300, 400, 500, "R8");
        px(300, 400, 500, "R8");
        // coefficient write to active bank while pixels stream
        step(1, 0, 0, {16'd0, 16'd16384}, 1, 50, 60, 70, "R8");
        px(50, 60, 70, "R8");
        idle(5);

        // R10: outputs hold while idle
        begin
            logic [3*W-1:0] held;
            held = last_out;
            idle(3);
            check("R10", {pix_out_r, pix_out_g, pix_out_b} == held && pix_valid_out == 0,
                  $sformatf("got %0h exp %0h", {pix_out_r, pix_out_g, pix_out_b}, held));
        end

        check("R2", seen == sent && exp_q.size() == 0,
              $sformatf("got results=%0d exp %0d", seen, sent));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule